// File: doc/BRIEF.md
# Four-Lane Co-Issue Vector ALU

This block is a pipelined arithmetic unit for four-component vectors whose lanes are named R, G, B and A. Every lane holds a 16-bit signed fixed-point number with eight fraction bits (Q8.8). Each issue slot carries two instruction halves, a main half and a side half. The main half brings its own operation code, three source vectors and a write mask, and the side half brings the same set. A two-bit mode field chooses how the lanes are shared between the halves. In the full mode the main half owns all four lanes. In the 3:1 mode the main half owns R, G and B and the side half owns A. In the 2:2 mode the main half owns R and G and the side half owns B and A.

Each half runs multiply, multiply-add, a four-term dot product, or a half-local dot product. The half-local dot product sums only the lanes its half owns and copies that sum to each of those lanes. The A lane result can be replaced by a complex-function value that arrives from outside the block. Results appear two clock cycles after issue, together with a per-lane write-enable vector. A downstream register file uses that vector to commit the lanes.

Top module: `vec_coissue_alu`

## Requirements
- R1: While reset is active and after it is released, out_valid, out_err, out_wen and out_data are all zero until the first issued instruction reaches the outputs.
- R2: An instruction sampled with in_valid high at clock edge n shows out_valid high after edge n+2. Back-to-back issues come out back to back in order. out_valid is low in cycles that carry no instruction.
- R3: The lanes are packed R in bits 15:0, G in 31:16, B in 47:32 and A in 63:48. Operation code 00 multiplies a by b. The Q8.8 product is rounded to nearest, with ties going toward positive infinity.
- R4: Operation code 01 computes a*b + c and rounds only once, after the addition.
- R5: Every result saturates to the 16-bit signed range, 0x8000 to 0x7FFF.
- R6: Operation code 10 (four-term dot product) in full mode adds the four lane products, rounds the total once, and places it in all four lanes.
- R7: Mode 01 (3:1) takes R, G and B from the main half's operands, operation and mask. It takes A from the side half's.
- R8: Mode 10 (2:2) takes R and G from the main half and takes B and A from the side half.
- R9: Operation code 11 (half dot product) adds only the products of lanes owned by its half and places the rounded sum in those lanes. In full mode it gives the same result as code 10.
- R10: out_wen for a lane equals the mask bit of the half that owns the lane. In full mode the side half's operation, operands and mask have no effect.
- R11: A code-10 dot product in mode 01 or 10, in either half, sets out_err and clears all of out_wen for that instruction.
- R12: Mode 11 writes nothing and raises no error. out_valid still pulses.
- R13: When cfn_sel is high, the A lane result is cfn_val, whatever the mode and operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction issue strobe |
| in_mode | input | 2 | Lane split: 00 full, 01 3:1, 10 2:2, 11 no-op |
| op_main | input | 2 | Main half operation code |
| op_side | input | 2 | Side half operation code |
| mask_main | input | 4 | Main half lane write mask (bit 0 = R) |
| mask_side | input | 4 | Side half lane write mask (bit 0 = R) |
| src_a_main | input | 64 | Main half operand a, four Q8.8 lanes |
| src_b_main | input | 64 | Main half operand b |
| src_c_main | input | 64 | Main half addend c |
| src_a_side | input | 64 | Side half operand a |
| src_b_side | input | 64 | Side half operand b |
| src_c_side | input | 64 | Side half addend c |
| cfn_sel | input | 1 | Replace the A lane result with cfn_val |
| cfn_val | input | 16 | Complex-function result for lane A |
| out_valid | output | 1 | Result strobe |
| out_wen | output | 4 | Per-lane write enable |
| out_err | output | 1 | Illegal dot product in a split mode |
| out_data | output | 64 | Four result lanes |

## Verification
The bench builds the block with its default widths: 16-bit lanes and eight fraction bits. With these widths the rounding tie points at 0x80 of a raw product can be reached. Both saturation rails can also be reached with a single multiply, or a multiply-add, of extreme operands. A four-term sum of sub-LSB products exposes any per-product rounding. The lane-split vectors place junk values in the lanes a half does not own, so any leak between halves appears in the written lanes.

// File: rtl/vcalu_pkg.sv
package vcalu_pkg;
  localparam int LANES = 4;

  typedef enum logic [1:0] {
    OP_MUL = 2'b00,
    OP_MAD = 2'b01,
    OP_DP4 = 2'b10,
    OP_DPH = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    MD_FULL = 2'b00,
    MD_S31  = 2'b01,
    MD_S22  = 2'b10,
    MD_NOP  = 2'b11
  } mode_e;
endpackage

// File: rtl/vcalu_decode.sv
module vcalu_decode
  import vcalu_pkg::*;
(
  input  logic                  valid,
  input  logic [1:0]            mode,
  input  logic [1:0]            opm,
  input  logic [1:0]            ops,
  input  logic [LANES-1:0]      mskm,
  input  logic [LANES-1:0]      msks,
  output logic [LANES-1:0]      own_p,
  output logic [LANES-1:0]      own_s,
  output logic [LANES-1:0][1:0] lane_op,
  output logic [LANES-1:0]      wen,
  output logic                  err
);
  logic split;

  always_comb begin
    unique case (mode)
      MD_FULL: begin own_p = 4'b1111; own_s = 4'b0000; end
      MD_S31:  begin own_p = 4'b0111; own_s = 4'b1000; end
      MD_S22:  begin own_p = 4'b0011; own_s = 4'b1100; end
      default: begin own_p = 4'b0000; own_s = 4'b0000; end
    endcase
    split = (mode == MD_S31) || (mode == MD_S22);
    err   = valid && split && ((opm == OP_DP4) || (ops == OP_DP4));
    for (int i = 0; i < LANES; i++) begin
      lane_op[i] = own_p[i] ? opm : ops;
    end
    wen = (valid && !err) ? ((own_p & mskm) | (own_s & msks)) : '0;
  end
endmodule

// File: rtl/vcalu_mul_stage.sv
module vcalu_mul_stage
  import vcalu_pkg::*;
#(
  parameter int W    = 16,
  parameter int FRAC = 8
) (
  input  logic [LANES-1:0]          own_p,
  input  logic [LANES-1:0][W-1:0]   a_p,
  input  logic [LANES-1:0][W-1:0]   b_p,
  input  logic [LANES-1:0][W-1:0]   c_p,
  input  logic [LANES-1:0][W-1:0]   a_s,
  input  logic [LANES-1:0][W-1:0]   b_s,
  input  logic [LANES-1:0][W-1:0]   c_s,
  output logic [LANES-1:0][2*W-1:0] prod,
  output logic [LANES-1:0][2*W-1:0] addend
);
  localparam int PW = 2 * W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic signed [W-1:0]  a_sel;
    logic signed [W-1:0]  b_sel;
    logic        [W-1:0]  c_sel;
    logic signed [PW-1:0] p;
    assign a_sel = own_p[i] ? a_p[i] : a_s[i];
    assign b_sel = own_p[i] ? b_p[i] : b_s[i];
    assign c_sel = own_p[i] ? c_p[i] : c_s[i];
    assign p     = a_sel * b_sel;
    assign prod[i]   = p;
    assign addend[i] = {{(W-FRAC){c_sel[W-1]}}, c_sel, {FRAC{1'b0}}};
  end
endmodule

// File: rtl/vcalu_reduce_sat.sv
module vcalu_reduce_sat
  import vcalu_pkg::*;
#(
  parameter int W    = 16,
  parameter int FRAC = 8
) (
  input  logic [LANES-1:0][2*W-1:0] prod,
  input  logic [LANES-1:0][2*W-1:0] addend,
  input  logic [LANES-1:0][1:0]     lane_op,
  input  logic [LANES-1:0]          own_p,
  input  logic [LANES-1:0]          own_s,
  input  logic                      cfn_sel,
  input  logic [W-1:0]              cfn_val,
  output logic [LANES-1:0][W-1:0]   res
);
  localparam int PW = 2 * W;
  localparam int SW = PW + 2;
  localparam logic signed [SW-1:0] RND  = SW'(1) << (FRAC - 1);
  localparam logic signed [SW-1:0] MAXV = {{(SW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {{(SW-W+1){1'b1}}, {(W-1){1'b0}}};

  logic signed [SW-1:0] ext_p [LANES];
  logic signed [SW-1:0] ext_c [LANES];
  logic signed [SW-1:0] sum_p;
  logic signed [SW-1:0] sum_s;

  for (genvar i = 0; i < LANES; i++) begin : g_ext
    assign ext_p[i] = {{2{prod[i][PW-1]}}, prod[i]};
    assign ext_c[i] = {{2{addend[i][PW-1]}}, addend[i]};
  end

  always_comb begin
    sum_p = '0;
    sum_s = '0;
    for (int i = 0; i < LANES; i++) begin
      if (own_p[i]) sum_p = sum_p + ext_p[i];
      if (own_s[i]) sum_s = sum_s + ext_p[i];
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_out
    logic signed [SW-1:0] acc;
    logic signed [SW-1:0] rnd;
    logic signed [SW-1:0] shv;
    logic        [W-1:0]  sat;

    always_comb begin
      unique case (lane_op[i])
        OP_MUL:  acc = ext_p[i];
        OP_MAD:  acc = ext_p[i] + ext_c[i];
        default: acc = own_p[i] ? sum_p : sum_s;
      endcase
      rnd = acc + RND;
      shv = rnd >>> FRAC;
      if (shv > MAXV)      sat = MAXV[W-1:0];
      else if (shv < MINV) sat = MINV[W-1:0];
      else                 sat = shv[W-1:0];
    end

    if (i == LANES - 1) begin : g_cfn
      assign res[i] = cfn_sel ? cfn_val : sat;
    end else begin : g_plain
      assign res[i] = sat;
    end
  end
endmodule

// File: rtl/vec_coissue_alu.sv
module vec_coissue_alu
  import vcalu_pkg::*;
#(
  parameter int W    = 16,
  parameter int FRAC = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0]           in_mode,
  input  logic [1:0]           op_main,
  input  logic [1:0]           op_side,
  input  logic [LANES-1:0]     mask_main,
  input  logic [LANES-1:0]     mask_side,
  input  logic [LANES*W-1:0]   src_a_main,
  input  logic [LANES*W-1:0]   src_b_main,
  input  logic [LANES*W-1:0]   src_c_main,
  input  logic [LANES*W-1:0]   src_a_side,
  input  logic [LANES*W-1:0]   src_b_side,
  input  logic [LANES*W-1:0]   src_c_side,
  input  logic                 cfn_sel,
  input  logic [W-1:0]         cfn_val,
  output logic                 out_valid,
  output logic [LANES-1:0]     out_wen,
  output logic                 out_err,
  output logic [LANES*W-1:0]   out_data
);
  localparam int PW = 2 * W;

  logic rst_meta, rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_int  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_int  <= rst_meta;
    end
  end

  logic [LANES-1:0]          d_own_p, d_own_s, d_wen;
  logic [LANES-1:0][1:0]     d_lane_op;
  logic                      d_err;
  logic [LANES-1:0][PW-1:0]  m_prod, m_add;

  vcalu_decode u_dec (
    .valid   (in_valid),
    .mode    (in_mode),
    .opm     (op_main),
    .ops     (op_side),
    .mskm    (mask_main),
    .msks    (mask_side),
    .own_p   (d_own_p),
    .own_s   (d_own_s),
    .lane_op (d_lane_op),
    .wen     (d_wen),
    .err     (d_err)
  );

  vcalu_mul_stage #(.W(W), .FRAC(FRAC)) u_mul (
    .own_p  (d_own_p),
    .a_p    (src_a_main),
    .b_p    (src_b_main),
    .c_p    (src_c_main),
    .a_s    (src_a_side),
    .b_s    (src_b_side),
    .c_s    (src_c_side),
    .prod   (m_prod),
    .addend (m_add)
  );

  // stage 1 state
  logic                      s1_valid, s1_valid_d;
  logic [LANES-1:0][PW-1:0]  s1_prod, s1_add;
  logic [LANES-1:0][1:0]     s1_op;
  logic [LANES-1:0]          s1_own_p, s1_own_s, s1_wen, s1_wen_d;
  logic                      s1_err, s1_err_d;
  logic                      s1_cfn_sel;
  logic [W-1:0]              s1_cfn_val;
  logic                      s1_ld;

  always_comb begin
    s1_ld      = in_valid;
    s1_valid_d = in_valid;
    s1_wen_d   = in_valid ? d_wen : '0;
    s1_err_d   = in_valid && d_err;
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      s1_valid   <= 1'b0;
      s1_wen     <= '0;
      s1_err     <= 1'b0;
      s1_prod    <= '0;
      s1_add     <= '0;
      s1_op      <= '0;
      s1_own_p   <= '0;
      s1_own_s   <= '0;
      s1_cfn_sel <= 1'b0;
      s1_cfn_val <= '0;
    end else begin
      s1_valid <= s1_valid_d;
      s1_wen   <= s1_wen_d;
      s1_err   <= s1_err_d;
      if (s1_ld) begin
        s1_prod    <= m_prod;
        s1_add     <= m_add;
        s1_op      <= d_lane_op;
        s1_own_p   <= d_own_p;
        s1_own_s   <= d_own_s;
        s1_cfn_sel <= cfn_sel;
        s1_cfn_val <= cfn_val;
      end
    end
  end

  logic [LANES-1:0][W-1:0] r_res;

  vcalu_reduce_sat #(.W(W), .FRAC(FRAC)) u_red (
    .prod    (s1_prod),
    .addend  (s1_add),
    .lane_op (s1_op),
    .own_p   (s1_own_p),
    .own_s   (s1_own_s),
    .cfn_sel (s1_cfn_sel),
    .cfn_val (s1_cfn_val),
    .res     (r_res)
  );

  // stage 2 state
  logic                  o_valid_d, o_err_d, o_ld;
  logic [LANES-1:0]      o_wen_d;

  always_comb begin
    o_ld      = s1_valid;
    o_valid_d = s1_valid;
    o_wen_d   = s1_valid ? s1_wen : '0;
    o_err_d   = s1_valid && s1_err;
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      out_valid <= 1'b0;
      out_wen   <= '0;
      out_err   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= o_valid_d;
      out_wen   <= o_wen_d;
      out_err   <= o_err_d;
      if (o_ld) out_data <= r_res;
    end
  end
endmodule

// File: rtl/vcalu_chk.sv
module vcalu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [1:0] in_mode,
  input logic [1:0] op_main,
  input logic [1:0] op_side,
  input logic       out_valid,
  input logic [3:0] out_wen,
  input logic       out_err
);
  logic [1:0] up_cnt;
  logic       armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              up_cnt <= 2'd0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end
  assign armed = (up_cnt == 2'd3);

  AST_ISSUE_TO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && in_valid) |-> ##2 out_valid);                                   // R2
  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !in_valid) |-> ##2 !out_valid);                                 // R2
  AST_WEN_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_wen == 4'b0000 && !out_err));                         // R10
  AST_ERR_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_wen == 4'b0000));                                        // R11
  AST_SPLIT_DOT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && in_valid && (in_mode == 2'b01 || in_mode == 2'b10) &&
     (op_main == 2'b10 || op_side == 2'b10)) |-> ##2 out_err);                // R11
  AST_NOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && in_valid && in_mode == 2'b11) |-> ##2 (out_wen == 4'b0000 && !out_err)); // R12
  AST_FULL_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && in_valid && in_mode == 2'b00) |-> ##2 !out_err);                // R10
endmodule

bind vec_coissue_alu vcalu_chk u_chk (.*);

// File: tb/sim_vec_coissue_alu.sv
module sim_vec_coissue_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_mode = 2'b00, op_main = 2'b00, op_side = 2'b00;
  logic [3:0]  mask_main = 4'h0, mask_side = 4'h0;
  logic [63:0] src_a_main = '0, src_b_main = '0, src_c_main = '0;
  logic [63:0] src_a_side = '0, src_b_side = '0, src_c_side = '0;
  logic        cfn_sel = 1'b0;
  logic [15:0] cfn_val = '0;
  logic        out_valid, out_err;
  logic [3:0]  out_wen;
  logic [63:0] out_data;

  always #2 clk = ~clk;

  vec_coissue_alu u0 (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  opm;
    logic [1:0]  ops;
    logic [3:0]  mm;
    logic [3:0]  ms;
    logic        cs;
    logic [15:0] cv;
    logic [63:0] ap, bp, cp, as_, bs, cs_;
    logic [3:0]  ewen;
    logic        eerr;
    logic [63:0] edat;
    logic [7:0]  req;
  } vec_t;

  function automatic logic [63:0] L(input logic [15:0] r, g, b, a);
    return {a, b, g, r};
  endfunction

  localparam logic [15:0] J = 16'h7FFF;
  localparam int NV = 17;

  localparam vec_t TBL [NV] = '{
    // R3 multiply
    '{2'd0,2'd0,2'd0,4'hF,4'h0,1'b0,16'h0, L(16'h0200,16'h0080,16'hFF00,16'h0300), L(16'h0180,16'h0080,16'h0200,16'h0100), 64'h0, 64'h0,64'h0,64'h0, 4'hF,1'b0, L(16'h0300,16'h0040,16'hFE00,16'h0300), 8'd3},
    // R3 rounding ties and below-half
    '{2'd0,2'd0,2'd0,4'hF,4'h0,1'b0,16'h0, L(16'h0001,16'h0001,16'hFFFF,16'hFFFF), L(16'h0080,16'h007F,16'h0080,16'h0081), 64'h0, 64'h0,64'h0,64'h0, 4'hF,1'b0, L(16'h0001,16'h0000,16'h0000,16'hFFFF), 8'd3},
    // R4 multiply-add, partial mask (R10)
    '{2'd0,2'd1,2'd0,4'h5,4'h0,1'b0,16'h0, L(16'h0200,16'h0200,16'h0200,16'h0200), L(16'h0100,16'h0100,16'h0100,16'h0100), L(16'h0080,16'hFF00,16'h0100,16'h0100), 64'h0,64'h0,64'h0, 4'h5,1'b0, L(16'h0280,16'h0100,16'h0300,16'h0300), 8'd4},
    // R5 saturating multiply
    '{2'd0,2'd0,2'd0,4'hF,4'h0,1'b0,16'h0, L(16'h7FFF,16'h8000,16'h8000,16'h7FFF), L(16'h0100,16'h7FFF,16'h8000,16'h7FFF), 64'h0, 64'h0,64'h0,64'h0, 4'hF,1'b0, L(16'h7FFF,16'h8000,16'h7FFF,16'h7FFF), 8'd5},
    // R5 saturating multiply-add
    '{2'd0,2'd1,2'd0,4'hF,4'h0,1'b0,16'h0, L(16'h8000,16'h0100,16'h0100,16'h0100), L(16'h0100,16'h0100,16'h0100,16'h0100), L(16'hFF00,16'h8000,16'h7FFF,16'h0000), 64'h0,64'h0,64'h0, 4'hF,1'b0, L(16'h8000,16'h8100,16'h7FFF,16'h0100), 8'd5},
    // R6 four-term dot product
    '{2'd0,2'd2,2'd0,4'hF,4'h0,1'b0,16'h0, L(16'h0100,16'h0200,16'h0300,16'h0400), L(16'h0080,16'h0080,16'h0080,16'h0080), 64'h0, 64'h0,64'h0,64'h0, 4'hF,1'b0, L(16'h0500,16'h0500,16'h0500,16'h0500), 8'd6},
    // R6 single rounding of the total
    '{2'd0,2'd2,2'd0,4'hF,4'h0,1'b0,16'h0, L(16'h0001,16'h0001,16'h0001,16'h0001), L(16'h0040,16'h0040,16'h0040,16'h0040), 64'h0, 64'h0,64'h0,64'h0, 4'hF,1'b0, L(16'h0001,16'h0001,16'h0001,16'h0001), 8'd6},
    // R7 3:1 MAD main, MUL side
    '{2'd1,2'd1,2'd0,4'h7,4'h8,1'b0,16'h0, L(16'h0100,16'h0100,16'h0100,J), L(16'h0200,16'h0200,16'h0200,J), L(16'h0100,16'h0100,16'h0100,J), L(J,J,J,16'h0300), L(J,J,J,16'h0300), L(J,J,J,J), 4'hF,1'b0, L(16'h0300,16'h0300,16'h0300,16'h0900), 8'd7},
    // R8 2:2 half-dot main, MUL side
    '{2'd2,2'd3,2'd0,4'h3,4'h4,1'b0,16'h0, L(16'h0100,16'h0200,16'h1000,16'h1000), L(16'h0300,16'h0100,16'h1000,16'h1000), 64'h0, L(16'h1000,16'h1000,16'h0200,16'h0100), L(16'h1000,16'h1000,16'h0200,16'hFF00), 64'h0, 4'h7,1'b0, L(16'h0500,16'h0500,16'h0400,16'hFF00), 8'd8},
    // R9 3:1 half-dot on both halves
    '{2'd1,2'd3,2'd3,4'h7,4'h8,1'b0,16'h0, L(16'h0100,16'h0100,16'h0100,16'h0100), L(16'h0100,16'h0200,16'h0300,16'h0100), 64'h0, L(16'h0100,16'h0100,16'h0100,16'h0200), L(16'h0100,16'h0100,16'h0100,16'h0200), 64'h0, 4'hF,1'b0, L(16'h0600,16'h0600,16'h0600,16'h0400), 8'd9},
    // R9 half-dot in full mode equals four-term dot
    '{2'd0,2'd3,2'd0,4'hF,4'h0,1'b0,16'h0, L(16'h0100,16'h0200,16'h0300,16'h0400), L(16'h0080,16'h0080,16'h0080,16'h0080), 64'h0, 64'h0,64'h0,64'h0, 4'hF,1'b0, L(16'h0500,16'h0500,16'h0500,16'h0500), 8'd9},
    // R10 full mode ignores side op, operands and mask
    '{2'd0,2'd0,2'd2,4'hA,4'h5,1'b0,16'h0, L(16'h0100,16'h0100,16'h0100,16'h0100), L(16'h0200,16'h0200,16'h0200,16'h0200), 64'h0, L(J,J,J,J),L(J,J,J,J),L(J,J,J,J), 4'hA,1'b0, L(16'h0200,16'h0200,16'h0200,16'h0200), 8'd10},
    // R11 dot product in 3:1 side half
    '{2'd1,2'd0,2'd2,4'hF,4'hF,1'b0,16'h0, L(16'h0100,16'h0100,16'h0100,16'h0100), L(16'h0100,16'h0100,16'h0100,16'h0100), 64'h0, 64'h0,64'h0,64'h0, 4'h0,1'b1, 64'h0, 8'd11},
    // R11 dot product in 2:2 main half
    '{2'd2,2'd2,2'd0,4'hF,4'hF,1'b0,16'h0, L(16'h0100,16'h0100,16'h0100,16'h0100), L(16'h0100,16'h0100,16'h0100,16'h0100), 64'h0, 64'h0,64'h0,64'h0, 4'h0,1'b1, 64'h0, 8'd11},
    // R12 reserved mode writes nothing
    '{2'd3,2'd0,2'd0,4'hF,4'hF,1'b0,16'h0, L(16'h0100,16'h0100,16'h0100,16'h0100), L(16'h0100,16'h0100,16'h0100,16'h0100), 64'h0, 64'h0,64'h0,64'h0, 4'h0,1'b0, 64'h0, 8'd12},
    // R13 complex-function value in lane A, full mode
    '{2'd0,2'd0,2'd0,4'hF,4'h0,1'b1,16'h1234, L(16'h0100,16'h0100,16'h0100,16'h0100), L(16'h0300,16'h0300,16'h0300,16'h0300), 64'h0, 64'h0,64'h0,64'h0, 4'hF,1'b0, L(16'h0300,16'h0300,16'h0300,16'h1234), 8'd13},
    // R13 complex-function value in lane A, 3:1 with MAD side
    '{2'd1,2'd0,2'd1,4'h7,4'h8,1'b1,16'h5678, L(16'h0100,16'h0100,16'h0100,16'h0100), L(16'h0300,16'h0300,16'h0300,16'h0300), 64'h0, L(16'h0100,16'h0100,16'h0100,16'h0100), L(16'h0100,16'h0100,16'h0100,16'h0100), L(16'h0100,16'h0100,16'h0100,16'h0100), 4'hF,1'b0, L(16'h0300,16'h0300,16'h0300,16'h5678), 8'd13}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_valid   = 1'b1;
    in_mode    = v.mode;
    op_main    = v.opm;
    op_side    = v.ops;
    mask_main  = v.mm;
    mask_side  = v.ms;
    cfn_sel    = v.cs;
    cfn_val    = v.cv;
    src_a_main = v.ap;
    src_b_main = v.bp;
    src_c_main = v.cp;
    src_a_side = v.as_;
    src_b_side = v.bs;
    src_c_side = v.cs_;
  endtask

  task automatic expect_vec(input vec_t v);
    string tag;
    logic [63:0] lm;
    tag = $sformatf("R%0d", v.req);
    lm = {{16{v.ewen[3]}}, {16{v.ewen[2]}}, {16{v.ewen[1]}}, {16{v.ewen[0]}}};
    chk(out_valid == 1'b1, {tag, " valid"}, 64'(out_valid), 64'h1);
    chk(out_wen == v.ewen, {tag, " wen"}, 64'(out_wen), 64'(v.ewen));
    chk(out_err == v.eerr, {tag, " err"}, 64'(out_err), 64'(v.eerr));
    chk((out_data & lm) == (v.edat & lm), {tag, " data"}, out_data & lm, v.edat & lm);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end

  initial begin
    // R1: outputs during reset and after release
    repeat (3) @(negedge clk);
    chk({out_valid, out_err, out_wen} == 6'b0 && out_data == 64'h0, "R1 in reset",
        {out_data[57:0], out_valid, out_err, out_wen}, 64'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({out_valid, out_err, out_wen} == 6'b0 && out_data == 64'h0, "R1 after release",
        {out_data[57:0], out_valid, out_err, out_wen}, 64'h0);

    // table walk, one instruction in flight at a time
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      expect_vec(TBL[i]);
      @(negedge clk);
    end

    // R2: exact latency and back-to-back issue
    drive(TBL[0]);
    @(negedge clk);
    chk(out_valid == 1'b0, "R2 not after one edge", 64'(out_valid), 64'h0);
    drive(TBL[5]);
    @(negedge clk);
    in_valid = 1'b0;
    expect_vec(TBL[0]);
    @(negedge clk);
    expect_vec(TBL[5]);
    @(negedge clk);
    chk(out_valid == 1'b0 && out_wen == 4'h0, "R2 idle after burst", {59'h0, out_valid, out_wen}, 64'h0);

    done = 1'b1;
    report();
  end
endmodule